// File: doc/BRIEF.md
# Dual-bank 8-bit CPU register file

This block is the general-purpose register storage of a small 8-bit processor. It holds the accumulator, the flag byte and six general bytes arranged as three 16-bit pairs. It also holds a second, shadow copy of all eight bytes and a 16-bit stack pointer. Two independent byte read ports and one byte write port are addressed by a 3-bit register code. One 16-bit pair read port and one pair write port are addressed by a 2-bit pair code plus a set-select bit. The set-select bit picks whether pair code 3 means the stack pointer or the accumulator/flag pair.

Reads are combinational from the current register state, and all writes land at the rising clock edge. A 2-bit exchange command swaps storage in one cycle. It can trade the accumulator/flag pair with its shadow, trade the three general pairs with their shadows, or swap the DE and HL pairs inside the main bank. An exchange always has priority over writes issued in the same cycle.

Top module: `cpu_regbank`

## Requirements
- R1: After reset every main byte, every shadow byte and the stack pointer read as zero.
- R2: Byte codes are B=0, C=1, D=2, E=3, H=4, L=5, A=7. A byte write lands at the next rising edge. Both byte read ports return the addressed byte combinationally.
- R3: A byte write with code 6 changes no register, including the flag byte. A byte read with code 6 returns 8'h00.
- R4: With set-select 0, the pair codes are BC=0, DE=1, HL=2 and SP=3. In every pair value the first-named register is bits 15:8 (B is the high byte of BC).
- R5: With set-select 1, pair codes 0 to 2 are again BC, DE and HL, and code 3 is AF with A in bits 15:8 and the flag byte in bits 7:0. The flag byte is reachable only this way.
- R6: When a byte write and a pair write happen in the same cycle without an exchange, both take effect. Where they target the same byte, the pair write wins.
- R7: Exchange command 2'b01 swaps A and the flag byte with their shadow copies.
- R8: Exchange command 2'b10 swaps B, C, D, E, H and L with their shadow copies and leaves A and the flag byte unchanged.
- R9: Exchange command 2'b11 swaps the main-bank DE and HL pairs and leaves the shadow bank unchanged.
- R10: Any nonzero exchange command in a cycle drops the byte write and the pair write requested in that cycle.
- R11: No exchange command changes the stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rda_sel | input | 3 | Byte read port A register code |
| rda_data | output | 8 | Byte read port A data |
| rdb_sel | input | 3 | Byte read port B register code |
| rdb_data | output | 8 | Byte read port B data |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 3 | Byte write register code |
| wr_data | input | 8 | Byte write data |
| prd_code | input | 2 | Pair read code |
| prd_alt | input | 1 | Pair read set-select (1: code 3 is AF) |
| prd_data | output | 16 | Pair read data |
| pwr_en | input | 1 | Pair write enable |
| pwr_code | input | 2 | Pair write code |
| pwr_alt | input | 1 | Pair write set-select (1: code 3 is AF) |
| pwr_data | input | 16 | Pair write data |
| xchg_cmd | input | 2 | Exchange: 00 none, 01 AF/shadow, 10 BC-DE-HL/shadow, 11 DE/HL |

## Verification
On every cycle, the assertions check the following. Each exchange moves the right bytes between the banks, and the bytes it must spare stay put. The stack pointer survives every exchange. A code-6 byte write on its own leaves the whole bank unchanged. The byte read ports return zero for code 6. The bench's scenarios are the only place that shows the register code and pair code maps and the byte order within a pair. They also show the shadow bank's contents, which can only be seen by swapping them back. The same goes for the overlap rule between simultaneous byte and pair writes, and for the reset values seen through the ports.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

    parameter int DW        = 8;
    parameter int NREG      = 8;
    parameter int CODE_W    = 3;
    parameter int PCODE_W   = 2;
    localparam int PW       = 2 * DW;

    // Internal slot numbers: byte codes map 1:1, and the unused byte
    // code 6 slot holds the flag byte, reachable only as a pair.
    localparam logic [CODE_W-1:0] IDX_B = 3'd0;
    localparam logic [CODE_W-1:0] IDX_C = 3'd1;
    localparam logic [CODE_W-1:0] IDX_D = 3'd2;
    localparam logic [CODE_W-1:0] IDX_E = 3'd3;
    localparam logic [CODE_W-1:0] IDX_H = 3'd4;
    localparam logic [CODE_W-1:0] IDX_L = 3'd5;
    localparam logic [CODE_W-1:0] IDX_F = 3'd6;
    localparam logic [CODE_W-1:0] IDX_A = 3'd7;

    typedef enum logic [1:0] {
        XCH_NONE = 2'b00,
        XCH_AF   = 2'b01,
        XCH_ALL  = 2'b10,
        XCH_DEHL = 2'b11
    } xch_e;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] main;
        logic [NREG-1:0][DW-1:0] shad;
        logic [PW-1:0]           sp;
    } bank_s;

endpackage

// File: rtl/regbank_pair_map.sv
module regbank_pair_map
    import regbank_pkg::*;
(
    input  logic [PCODE_W-1:0] code,
    input  logic               alt,
    output logic [CODE_W-1:0]  hi_idx,
    output logic [CODE_W-1:0]  lo_idx,
    output logic               is_sp
);
    always_comb begin
        is_sp  = 1'b0;
        hi_idx = IDX_B;
        lo_idx = IDX_C;
        unique case (code)
            2'd0: begin hi_idx = IDX_B; lo_idx = IDX_C; end
            2'd1: begin hi_idx = IDX_D; lo_idx = IDX_E; end
            2'd2: begin hi_idx = IDX_H; lo_idx = IDX_L; end
            default: begin
                hi_idx = IDX_A;
                lo_idx = IDX_F;
                is_sp  = ~alt;
            end
        endcase
    end
endmodule

// File: rtl/regbank_rd_mux.sv
module regbank_rd_mux
    import regbank_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CODE_W-1:0]       sel,
    input  logic [NREG-1:0][DW-1:0] regs,
    output logic [DW-1:0]           data
);
    always_comb begin
        data = regs[sel];
        if (sel == IDX_F) data = '0;
    end

    // R3
    rd_code6_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == IDX_F) |-> (data == '0));
endmodule

// File: rtl/regbank_core.sv
module regbank_core
    import regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [CODE_W-1:0]  wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic               pwr_en,
    input  logic [CODE_W-1:0]  pwr_hi,
    input  logic [CODE_W-1:0]  pwr_lo,
    input  logic               pwr_sp,
    input  logic [PW-1:0]      pwr_data,
    input  logic [1:0]         xchg_cmd,
    output bank_s              bank_q
);
    bank_s bank_d;
    xch_e  cmd;
    logic [DW-1:0] tmp;

    assign cmd = xch_e'(xchg_cmd);

    always_comb begin
        bank_d = bank_q;
        tmp    = '0;
        unique case (cmd)
            XCH_AF: begin
                bank_d.main[IDX_A] = bank_q.shad[IDX_A];
                bank_d.shad[IDX_A] = bank_q.main[IDX_A];
                bank_d.main[IDX_F] = bank_q.shad[IDX_F];
                bank_d.shad[IDX_F] = bank_q.main[IDX_F];
            end
            XCH_ALL: begin
                for (int i = 0; i <= int'(IDX_L); i++) begin
                    bank_d.main[i] = bank_q.shad[i];
                    bank_d.shad[i] = bank_q.main[i];
                end
            end
            XCH_DEHL: begin
                bank_d.main[IDX_D] = bank_q.main[IDX_H];
                bank_d.main[IDX_E] = bank_q.main[IDX_L];
                bank_d.main[IDX_H] = bank_q.main[IDX_D];
                bank_d.main[IDX_L] = bank_q.main[IDX_E];
            end
            default: begin
                if (wr_en && (wr_sel != IDX_F)) begin
                    tmp = wr_data;
                    bank_d.main[wr_sel] = tmp;
                end
                if (pwr_en) begin
                    if (pwr_sp) begin
                        bank_d.sp = pwr_data;
                    end else begin
                        bank_d.main[pwr_hi] = pwr_data[PW-1:DW];
                        bank_d.main[pwr_lo] = pwr_data[DW-1:0];
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    // R7
    xaf_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == XCH_AF) |=> (bank_q.main[IDX_A] == $past(bank_q.shad[IDX_A]))
                         && (bank_q.shad[IDX_F] == $past(bank_q.main[IDX_F])));
    // R8
    xall_keeps_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == XCH_ALL) |=> $stable(bank_q.main[IDX_A]) && $stable(bank_q.main[IDX_F])
                          && (bank_q.main[IDX_H] == $past(bank_q.shad[IDX_H])));
    // R9
    xdehl_shadow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == XCH_DEHL) |=> $stable(bank_q.shad)
                           && (bank_q.main[IDX_D] == $past(bank_q.main[IDX_H])));
    // R11
    sp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != XCH_NONE) |=> $stable(bank_q.sp));
    // R3
    code6_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == IDX_F && !pwr_en && cmd == XCH_NONE) |=> $stable(bank_q));
endmodule

// File: rtl/cpu_regbank.sv
module cpu_regbank
    import regbank_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CODE_W-1:0]  rda_sel,
    output logic [DW-1:0]      rda_data,
    input  logic [CODE_W-1:0]  rdb_sel,
    output logic [DW-1:0]      rdb_data,
    input  logic               wr_en,
    input  logic [CODE_W-1:0]  wr_sel,
    input  logic [DW-1:0]      wr_data,
    input  logic [PCODE_W-1:0] prd_code,
    input  logic               prd_alt,
    output logic [PW-1:0]      prd_data,
    input  logic               pwr_en,
    input  logic [PCODE_W-1:0] pwr_code,
    input  logic               pwr_alt,
    input  logic [PW-1:0]      pwr_data,
    input  logic [1:0]         xchg_cmd
);
    localparam int NRD = 2;

    bank_s bank_q;
    logic [CODE_W-1:0] r_hi, r_lo, w_hi, w_lo;
    logic              r_sp, w_sp;
    logic [NRD-1:0][CODE_W-1:0] rd_sel;
    logic [NRD-1:0][DW-1:0]     rd_data;

    assign rd_sel[0] = rda_sel;
    assign rd_sel[1] = rdb_sel;
    assign rda_data  = rd_data[0];
    assign rdb_data  = rd_data[1];

    regbank_pair_map u_rmap (.code(prd_code), .alt(prd_alt),
                             .hi_idx(r_hi), .lo_idx(r_lo), .is_sp(r_sp));
    regbank_pair_map u_wmap (.code(pwr_code), .alt(pwr_alt),
                             .hi_idx(w_hi), .lo_idx(w_lo), .is_sp(w_sp));

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        regbank_rd_mux u_mux (.clk(clk), .rst_n(rst_n), .sel(rd_sel[g]),
                              .regs(bank_q.main), .data(rd_data[g]));
    end

    regbank_core u_core (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pwr_en(pwr_en), .pwr_hi(w_hi), .pwr_lo(w_lo), .pwr_sp(w_sp),
        .pwr_data(pwr_data), .xchg_cmd(xchg_cmd), .bank_q(bank_q)
    );

    always_comb begin
        if (r_sp) prd_data = bank_q.sp;
        else      prd_data = {bank_q.main[r_hi], bank_q.main[r_lo]};
    end

    // R10
    xchg_drops_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xchg_cmd == 2'b01 && wr_en && wr_sel == 3'd0) |=> $stable(bank_q.main[0]));
endmodule

// File: tb/cpu_regbank_tb.sv
module cpu_regbank_tb;
    logic clk = 1'b0, rst_n = 1'b0;
    logic [2:0] rda_sel = '0, rdb_sel = '0, wr_sel = '0;
    logic [7:0] rda_data, rdb_data, wr_data = '0;
    logic wr_en = 1'b0, prd_alt = 1'b0, pwr_en = 1'b0, pwr_alt = 1'b0;
    logic [1:0] prd_code = '0, pwr_code = '0, xchg_cmd = '0;
    logic [15:0] prd_data, pwr_data = '0;
    int checks = 0, fails = 0;

    always #4 clk = ~clk;

    cpu_regbank u_dut (.*);

    task automatic chk(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
        wr_en = 0; pwr_en = 0; xchg_cmd = 2'b00;
    endtask

    task automatic wr8(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1; wr_sel = s; wr_data = d; tick();
    endtask

    task automatic wrp(input logic [1:0] c, input logic a, input logic [15:0] d);
        pwr_en = 1; pwr_code = c; pwr_alt = a; pwr_data = d; tick();
    endtask

    task automatic xch(input logic [1:0] c);
        xchg_cmd = c; tick();
    endtask

    task automatic ck8(input logic [2:0] s, input logic [7:0] e, input string tag);
        rda_sel = s; rdb_sel = s; #1;
        chk(rda_data == e, tag, {8'h0, rda_data}, {8'h0, e});
        chk(rdb_data == e, tag, {8'h0, rdb_data}, {8'h0, e});
    endtask

    task automatic ckp(input logic [1:0] c, input logic a, input logic [15:0] e, input string tag);
        prd_code = c; prd_alt = a; #1;
        chk(prd_data == e, tag, prd_data, e);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) ck8(3'(i), 8'h00, "R1 byte");
        ckp(2'd3, 1'b0, 16'h0000, "R1 sp");
        ckp(2'd3, 1'b1, 16'h0000, "R1 af");
    endtask

    task automatic t_bytes();
        for (int i = 0; i < 8; i++) if (i != 6) wr8(3'(i), 8'(8'h11 * (i + 1)));
        for (int i = 0; i < 8; i++) if (i != 6) ck8(3'(i), 8'(8'h11 * (i + 1)), "R2 byte map");
        ckp(2'd0, 1'b0, 16'h1122, "R4 bc order");
        ckp(2'd2, 1'b1, 16'h5566, "R4 hl alt set");
    endtask

    task automatic t_code6();
        wr8(3'd6, 8'hEE);
        ck8(3'd6, 8'h00, "R3 code6 read");
        ckp(2'd3, 1'b1, 16'h8800, "R3 flag untouched");
        ck8(3'd5, 8'h66, "R3 L untouched");
    endtask

    task automatic t_pairs();
        wrp(2'd0, 1'b0, 16'h1234);
        ck8(3'd0, 8'h12, "R4 B high");
        ck8(3'd1, 8'h34, "R4 C low");
        wrp(2'd3, 1'b0, 16'hBEEF);
        ckp(2'd3, 1'b0, 16'hBEEF, "R4 sp");
        ck8(3'd7, 8'h88, "R4 sp write spares A");
        wrp(2'd3, 1'b1, 16'hA5C3);
        ck8(3'd7, 8'hA5, "R5 A high");
        ckp(2'd3, 1'b1, 16'hA5C3, "R5 af");
        ckp(2'd3, 1'b0, 16'hBEEF, "R5 sp spared");
    endtask

    task automatic t_conflict();
        wr_en = 1; wr_sel = 3'd0; wr_data = 8'h99;
        pwr_en = 1; pwr_code = 2'd0; pwr_alt = 0; pwr_data = 16'h5566; tick();
        ckp(2'd0, 1'b0, 16'h5566, "R6 overlap pair wins");
        wr_en = 1; wr_sel = 3'd7; wr_data = 8'h77;
        pwr_en = 1; pwr_code = 2'd1; pwr_alt = 0; pwr_data = 16'h1020; tick();
        ck8(3'd7, 8'h77, "R6 byte lands");
        ckp(2'd1, 1'b0, 16'h1020, "R6 pair lands");
    endtask

    task automatic t_xaf();
        wrp(2'd3, 1'b1, 16'h1122);
        xch(2'b01);
        ckp(2'd3, 1'b1, 16'h0000, "R7 shadow in");
        wrp(2'd3, 1'b1, 16'h3344);
        xch(2'b01);
        ckp(2'd3, 1'b1, 16'h1122, "R7 swap back");
        ckp(2'd0, 1'b0, 16'h5566, "R7 bc spared");
        xch(2'b01);
        ckp(2'd3, 1'b1, 16'h3344, "R7 swap again");
    endtask

    task automatic t_xall();
        wrp(2'd0, 1'b0, 16'hB0C0);
        wrp(2'd1, 1'b0, 16'hD0E0);
        wrp(2'd2, 1'b0, 16'h4050);
        xch(2'b10);
        ckp(2'd0, 1'b0, 16'h0000, "R8 bc shadow");
        ckp(2'd2, 1'b0, 16'h0000, "R8 hl shadow");
        ckp(2'd3, 1'b1, 16'h3344, "R8 af kept");
        ckp(2'd3, 1'b0, 16'hBEEF, "R11 sp after xall");
        xch(2'b10);
        ckp(2'd0, 1'b0, 16'hB0C0, "R8 bc back");
        ckp(2'd1, 1'b0, 16'hD0E0, "R8 de back");
        ckp(2'd2, 1'b0, 16'h4050, "R8 hl back");
    endtask

    task automatic t_xdehl();
        xch(2'b11);
        ckp(2'd1, 1'b0, 16'h4050, "R9 de gets hl");
        ckp(2'd2, 1'b0, 16'hD0E0, "R9 hl gets de");
        ckp(2'd0, 1'b0, 16'hB0C0, "R9 bc kept");
        xch(2'b10);
        ckp(2'd1, 1'b0, 16'h0000, "R9 shadow de kept");
        ckp(2'd2, 1'b0, 16'h0000, "R9 shadow hl kept");
        xch(2'b10);
    endtask

    task automatic t_prio();
        xchg_cmd = 2'b11; wr_en = 1; wr_sel = 3'd7; wr_data = 8'hFF;
        pwr_en = 1; pwr_code = 2'd3; pwr_alt = 0; pwr_data = 16'h0101; tick();
        ck8(3'd7, 8'h33, "R10 byte dropped");
        ckp(2'd3, 1'b0, 16'hBEEF, "R10 R11 sp kept");
        ckp(2'd1, 1'b0, 16'hD0E0, "R10 exchange done");
        xchg_cmd = 2'b01; pwr_en = 1; pwr_code = 2'd0; pwr_alt = 0; pwr_data = 16'h7777; tick();
        ckp(2'd0, 1'b0, 16'hB0C0, "R10 pair dropped");
        ckp(2'd3, 1'b1, 16'h1122, "R10 af swapped");
    endtask

    initial begin
        #20; rst_n = 1; #1;
        @(posedge clk); #1;
        t_reset(); t_bytes(); t_code6(); t_pairs(); t_conflict();
        t_xaf(); t_xall(); t_xdehl(); t_prio();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule